// File: doc/BRIEF.md
# Cascaded Interrupt Request Resolver

This block holds the pending-request, in-service and (externally supplied) mask state for a two-stage cascade of 8-line interrupt controllers. It treats the cascade as a single resolver covering 16 request lines. Peripherals and their glue logic pulse a raise or a lower for a numbered line. The resolver chooses the lowest-numbered unmasked pending line and offers a vector for it, taken from that line's half-specific base value. The processor side acknowledges by returning a vector, which moves the request into service. Later it retires the request with a decoded end-of-interrupt command, either specific (by level) or non-specific (lowest in-service bit).

Line 2 is the cascade input of the lower half. A raise on it is redirected to line 9 and also marks lower-half bit 2 pending. Masks and bases are inputs driven by whatever holds the programming state. Priority is fixed and never rotates.

Top module: `irq_pair_resolver`

## Requirements
- R1: A raise on line n, 0 to 15, sets bit n of the pending vector `irr_o` at the next clock edge. Bits 7..0 form the lower half (lines 0 to 7), and bits 15..8 form the upper half (lines 8 to 15, line 8 + k on upper bit k).
- R2: A raise on line 2 sets both `irr_o[2]` and `irr_o[9]`. A lower on line 2 clears only `irr_o[2]`.
- R3: A raise on a line number of 16 or more changes no pending bit and drives `raise_err` high for exactly the cycle after the edge that took it.
- R4: A lower on line n, 0 to 15, clears `irr_o[n]` at the next edge.
- R5: The resolver picks the lowest line n with `irr_o[n]` set and its mask bit clear. The mask bit is `mask_lo[n]` for n < 8 and `mask_hi[n-8]` otherwise. It then drives `vec_valid`=`irq_out`=1 and `vec` = `base_lo`+n or `base_hi`+(n-8), modulo 256, all without a register stage. With no such line, `vec_valid`, `irq_out` and `vec` are 0.
- R6: An acknowledge of vector v is tested against the lower half first. If (v-`base_lo`) mod 256 = k < 8, then at the next edge `isr_o[k]` is set and `irr_o[k]` is cleared. Otherwise, if (v-`base_hi`) mod 256 = k < 8, the same happens to bit 8+k. Otherwise the acknowledge is ignored.
- R7: A specific end-of-interrupt (`eoi_specific`=1) clears in-service bit `eoi_level` of the half selected by `eoi_hi` (0 = lower, 1 = upper) at the next edge.
- R8: A non-specific end-of-interrupt (`eoi_specific`=0) clears only the lowest set in-service bit of the selected half. The other half is untouched.
- R9: In the cycle after the edge that applies an end-of-interrupt, `eoi_err` equals `irq_out`. In every other cycle it is 0.
- R10: A synchronous active-low reset clears all pending and in-service bits and both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raise_vld | input | 1 | Raise pulse for `raise_line` |
| raise_line | input | 5 | Line number to raise |
| lower_vld | input | 1 | Lower pulse for `lower_line` |
| lower_line | input | 5 | Line number to lower |
| mask_lo | input | 8 | Mask for lines 0 to 7 |
| mask_hi | input | 8 | Mask for lines 8 to 15 |
| base_lo | input | 8 | Vector base for lines 0 to 7 |
| base_hi | input | 8 | Vector base for lines 8 to 15 |
| ack_vld | input | 1 | Acknowledge strobe |
| ack_vec | input | 8 | Vector being acknowledged |
| eoi_vld | input | 1 | End-of-interrupt strobe |
| eoi_hi | input | 1 | Half addressed by the end-of-interrupt (1 = upper) |
| eoi_specific | input | 1 | 1 = specific, 0 = non-specific |
| eoi_level | input | 3 | In-service bit for a specific end-of-interrupt |
| irq_out | output | 1 | Any unmasked request pending |
| vec_valid | output | 1 | `vec` holds a resolved vector |
| vec | output | 8 | Vector of the winning line |
| irr_o | output | 16 | Pending bits, upper half in 15..8 |
| isr_o | output | 16 | In-service bits, upper half in 15..8 |
| raise_err | output | 1 | Out-of-range raise seen on the previous edge |
| eoi_err | output | 1 | Request still resolvable right after an end-of-interrupt |

## Verification
Each corruption of internal state shows up at the ports one clock after the stimulus that causes it. A bad pending bit appears in `irr_o`, and, when unmasked, it changes `vec` and `irq_out` in the same cycle. A bad in-service bit shows in `isr_o` and, through a mismatched acknowledge or end-of-interrupt, in the next cycle's value. The directed scenarios therefore sample both vectors and the resolved vector one edge after every pulse. They cover the cascade redirection, the half-window test on acknowledge and the lowest-bit choice of the non-specific end-of-interrupt.

// File: rtl/irq_pair_pkg.sv
// Package: shared defaults and command encodings for the cascaded resolver.
// Assumes: two halves of equal width; vectors are plain unsigned bytes.
package irq_pair_pkg;
    localparam int DEF_HALF_W = 8;
    localparam int DEF_VEC_W  = 8;

    typedef enum logic {
        EOI_LOWEST   = 1'b0,
        EOI_BY_LEVEL = 1'b1
    } eoi_kind_e;
endpackage

// File: rtl/irq_line_decode.sv
// Module: turns raise/lower pulses with a line number into per-line set and
// clear masks, applying the cascade redirection and range rejection.
// Assumes: LINE_W is one bit wider than the line index so over-range
// numbers can be expressed.
module irq_line_decode #(
    parameter int LINES      = 16,
    parameter int LINE_W     = 5,
    parameter int CASC_LINE  = 2,
    parameter int REDIR_LINE = 9
) (
    input  logic              raise_vld,
    input  logic [LINE_W-1:0] raise_line,
    input  logic              lower_vld,
    input  logic [LINE_W-1:0] lower_line,
    output logic [LINES-1:0]  set_mask,
    output logic [LINES-1:0]  clr_mask,
    output logic              bad_raise
);
    localparam int IDX_W = $clog2(LINES);
    localparam logic [LINE_W-1:0] LIMIT = LINE_W'(LINES);
    localparam logic [LINE_W-1:0] CASC  = LINE_W'(CASC_LINE);

    // Decode both pulses into one-hot masks; flag out-of-range raises.
    always_comb begin
        set_mask  = '0;
        clr_mask  = '0;
        bad_raise = 1'b0;
        if (raise_vld) begin
            if (raise_line < LIMIT) begin
                set_mask[raise_line[IDX_W-1:0]] = 1'b1;
                if (raise_line == CASC) begin
                    set_mask[REDIR_LINE] = 1'b1;
                end
            end else begin
                bad_raise = 1'b1;
            end
        end
        if (lower_vld && (lower_line < LIMIT)) begin
            clr_mask[lower_line[IDX_W-1:0]] = 1'b1;
        end
    end
endmodule

// File: rtl/irq_half_regs.sv
// Module: pending and in-service registers of one half, with acknowledge
// transfer and specific / lowest-bit end-of-interrupt retirement.
// Assumes: ack_take is zero or one-hot; a lower beats a raise on one bit.
module irq_half_regs #(
    parameter int HALF_W = 8,
    parameter int LVL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] set_bits,
    input  logic [HALF_W-1:0] clr_bits,
    input  logic [HALF_W-1:0] ack_take,
    input  logic              eoi_vld,
    input  logic              eoi_spec,
    input  logic [LVL_W-1:0]  eoi_lvl,
    output logic [HALF_W-1:0] irr,
    output logic [HALF_W-1:0] isr
);
    logic [HALF_W-1:0] eoi_clr;

    // Select the in-service bit to retire: by level, or the lowest set bit.
    always_comb begin
        eoi_clr = '0;
        if (eoi_vld) begin
            if (eoi_spec) begin
                eoi_clr = HALF_W'(1) << eoi_lvl;
            end else begin
                eoi_clr = isr & (~isr + HALF_W'(1));
            end
        end
    end

    // Update pending and in-service state each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr <= '0;
            isr <= '0;
        end else begin
            irr <= (irr | set_bits) & ~clr_bits & ~ack_take;
            isr <= (isr | ack_take) & ~eoi_clr;
        end
    end
endmodule

// File: rtl/irq_prio_scan.sv
// Module: fixed-priority scan over all lines; lowest index wins and its
// vector is formed from the owning half's base.
// Assumes: pend is already masked.
module irq_prio_scan #(
    parameter int LINES  = 16,
    parameter int HALF_W = 8,
    parameter int VEC_W  = 8
) (
    input  logic [LINES-1:0] pend,
    input  logic [VEC_W-1:0] base_lo,
    input  logic [VEC_W-1:0] base_hi,
    output logic             hit,
    output logic [VEC_W-1:0] vec
);
    // Walk from the top down so the lowest pending line is assigned last.
    always_comb begin
        hit = 1'b0;
        vec = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                hit = 1'b1;
                if (i < HALF_W) begin
                    vec = base_lo + VEC_W'(i);
                end else begin
                    vec = base_hi + VEC_W'(i - HALF_W);
                end
            end
        end
    end
endmodule

// File: rtl/irq_pair_resolver.sv
// Module: top of the cascaded resolver. Decodes line pulses, holds two
// halves of state, resolves the winning vector, routes acknowledges and
// end-of-interrupt commands, and registers the two error flags.
// Assumes: masks and bases are stable programming inputs.
module irq_pair_resolver
    import irq_pair_pkg::*;
#(
    parameter int HALF_W     = DEF_HALF_W,
    parameter int VEC_W      = DEF_VEC_W,
    parameter int CASC_LINE  = 2,
    parameter int REDIR_LINE = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      raise_vld,
    input  logic [$clog2(2*HALF_W):0] raise_line,
    input  logic                      lower_vld,
    input  logic [$clog2(2*HALF_W):0] lower_line,
    input  logic [HALF_W-1:0]         mask_lo,
    input  logic [HALF_W-1:0]         mask_hi,
    input  logic [VEC_W-1:0]          base_lo,
    input  logic [VEC_W-1:0]          base_hi,
    input  logic                      ack_vld,
    input  logic [VEC_W-1:0]          ack_vec,
    input  logic                      eoi_vld,
    input  logic                      eoi_hi,
    input  logic                      eoi_specific,
    input  logic [$clog2(HALF_W)-1:0] eoi_level,
    output logic                      irq_out,
    output logic                      vec_valid,
    output logic [VEC_W-1:0]          vec,
    output logic [2*HALF_W-1:0]       irr_o,
    output logic [2*HALF_W-1:0]       isr_o,
    output logic                      raise_err,
    output logic                      eoi_err
);
    localparam int LINES  = 2 * HALF_W;
    localparam int LINE_W = $clog2(LINES) + 1;
    localparam int LVL_W  = $clog2(HALF_W);
    localparam logic [VEC_W-1:0] WINDOW = VEC_W'(HALF_W);

    logic [LINES-1:0] set_mask, clr_mask, ack_take;
    logic             bad_raise, hit;
    logic [VEC_W-1:0] diff_lo, diff_hi;
    logic             in_lo, in_hi;
    logic             raise_err_q, eoi_seen_q;

    irq_line_decode #(
        .LINES(LINES), .LINE_W(LINE_W),
        .CASC_LINE(CASC_LINE), .REDIR_LINE(REDIR_LINE)
    ) u_decode (
        .raise_vld(raise_vld), .raise_line(raise_line),
        .lower_vld(lower_vld), .lower_line(lower_line),
        .set_mask(set_mask), .clr_mask(clr_mask), .bad_raise(bad_raise)
    );

    // Locate the acknowledged vector inside a half's window, lower half first.
    always_comb begin
        diff_lo  = ack_vec - base_lo;
        diff_hi  = ack_vec - base_hi;
        in_lo    = diff_lo < WINDOW;
        in_hi    = diff_hi < WINDOW;
        ack_take = '0;
        if (ack_vld) begin
            if (in_lo) begin
                ack_take[HALF_W-1:0] = HALF_W'(1) << diff_lo[LVL_W-1:0];
            end else if (in_hi) begin
                ack_take[LINES-1:HALF_W] = HALF_W'(1) << diff_hi[LVL_W-1:0];
            end
        end
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        irq_half_regs #(.HALF_W(HALF_W), .LVL_W(LVL_W)) u_regs (
            .clk(clk), .rst_n(rst_n),
            .set_bits(set_mask[h*HALF_W +: HALF_W]),
            .clr_bits(clr_mask[h*HALF_W +: HALF_W]),
            .ack_take(ack_take[h*HALF_W +: HALF_W]),
            .eoi_vld(eoi_vld && (eoi_hi == 1'(h))),
            .eoi_spec(eoi_specific == EOI_BY_LEVEL),
            .eoi_lvl(eoi_level),
            .irr(irr_o[h*HALF_W +: HALF_W]),
            .isr(isr_o[h*HALF_W +: HALF_W])
        );
    end

    irq_prio_scan #(.LINES(LINES), .HALF_W(HALF_W), .VEC_W(VEC_W)) u_scan (
        .pend(irr_o & ~{mask_hi, mask_lo}),
        .base_lo(base_lo), .base_hi(base_hi),
        .hit(hit), .vec(vec)
    );

    // Register the one-cycle error indications.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raise_err_q <= 1'b0;
            eoi_seen_q  <= 1'b0;
        end else begin
            raise_err_q <= bad_raise;
            eoi_seen_q  <= eoi_vld;
        end
    end

    assign irq_out   = hit;
    assign vec_valid = hit;
    assign raise_err = raise_err_q;
    assign eoi_err   = eoi_seen_q & hit;
endmodule

// File: rtl/irq_pair_resolver_chk.sv
// Module: temporal checks on the resolver's ports, attached by bind.
// Assumes: same parameter values as the bound instance.
module irq_pair_resolver_chk #(
    parameter int HALF_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      raise_vld,
    input logic [$clog2(2*HALF_W):0] raise_line,
    input logic                      lower_vld,
    input logic [$clog2(2*HALF_W):0] lower_line,
    input logic                      ack_vld,
    input logic                      eoi_vld,
    input logic                      eoi_hi,
    input logic                      eoi_specific,
    input logic [$clog2(HALF_W)-1:0] eoi_level,
    input logic [2*HALF_W-1:0]       irr_o,
    input logic [2*HALF_W-1:0]       isr_o,
    input logic                      raise_err,
    input logic                      eoi_err
);
    localparam int LINES  = 2 * HALF_W;
    localparam int IDX_W  = $clog2(LINES);
    localparam int LINE_W = IDX_W + 1;
    localparam logic [LINE_W-1:0] LIMIT = LINE_W'(LINES);

    AST_RAISE_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_vld && raise_line < LIMIT && !lower_vld && !ack_vld)
        |=> irr_o[$past(raise_line[IDX_W-1:0])]); // R1

    AST_BAD_LINE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_vld && raise_line >= LIMIT) |=> raise_err); // R3

    AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        raise_err |-> $past(raise_vld)); // R3

    AST_LOWER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (lower_vld && lower_line < LIMIT && !raise_vld)
        |=> !irr_o[$past(lower_line[IDX_W-1:0])]); // R4

    AST_SERVICE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_vld |=> ((isr_o & ~$past(isr_o)) == '0)); // R6

    AST_LEVEL_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_vld && eoi_specific && !ack_vld)
        |=> !isr_o[{$past(eoi_hi), $past(eoi_level)}]); // R7

    AST_LOWEST_EOI_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_vld && !eoi_specific && !ack_vld)
        |=> (($countones($past(isr_o)) - $countones(isr_o)) <= 1)); // R8

    AST_EOI_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_err |-> $past(eoi_vld)); // R9
endmodule

bind irq_pair_resolver irq_pair_resolver_chk #(.HALF_W(HALF_W)) u_chk (.*);

// File: tb/irq_pair_resolver_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module irq_pair_resolver_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raise_vld = 1'b0, lower_vld = 1'b0;
    logic [4:0]  raise_line = '0, lower_line = '0;
    logic [7:0]  mask_lo = '0, mask_hi = '0;
    logic [7:0]  base_lo = 8'h20, base_hi = 8'h70;
    logic        ack_vld = 1'b0;
    logic [7:0]  ack_vec = '0;
    logic        eoi_vld = 1'b0, eoi_hi = 1'b0, eoi_specific = 1'b0;
    logic [2:0]  eoi_level = '0;
    logic        irq_out, vec_valid, raise_err, eoi_err;
    logic [7:0]  vec;
    logic [15:0] irr_o, isr_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_pair_resolver u_irq_pair_resolver (
        .clk(clk), .rst_n(rst_n),
        .raise_vld(raise_vld), .raise_line(raise_line),
        .lower_vld(lower_vld), .lower_line(lower_line),
        .mask_lo(mask_lo), .mask_hi(mask_hi),
        .base_lo(base_lo), .base_hi(base_hi),
        .ack_vld(ack_vld), .ack_vec(ack_vec),
        .eoi_vld(eoi_vld), .eoi_hi(eoi_hi),
        .eoi_specific(eoi_specific), .eoi_level(eoi_level),
        .irq_out(irq_out), .vec_valid(vec_valid), .vec(vec),
        .irr_o(irr_o), .isr_o(isr_o),
        .raise_err(raise_err), .eoi_err(eoi_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic raise(input logic [4:0] n);
        @(negedge clk); raise_vld = 1'b1; raise_line = n;
        @(negedge clk); raise_vld = 1'b0;
    endtask

    task automatic lower(input logic [4:0] n);
        @(negedge clk); lower_vld = 1'b1; lower_line = n;
        @(negedge clk); lower_vld = 1'b0;
    endtask

    task automatic ack(input logic [7:0] v);
        @(negedge clk); ack_vld = 1'b1; ack_vec = v;
        @(negedge clk); ack_vld = 1'b0;
    endtask

    task automatic eoi(input logic hi, input logic spec, input logic [2:0] lvl);
        @(negedge clk); eoi_vld = 1'b1; eoi_hi = hi; eoi_specific = spec; eoi_level = lvl;
        @(negedge clk); eoi_vld = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R10 irr after reset", 32'(irr_o), 32'h0);
        check("R10 isr after reset", 32'(isr_o), 32'h0);
        check("R5 no irq after reset", {31'b0, irq_out}, 32'h0);
        check("R5 vec_valid after reset", {31'b0, vec_valid}, 32'h0);
    endtask

    task automatic t_line_map();
        raise(5'd5);
        check("R1 line 5 lower half", 32'(irr_o), 32'h0020);
        raise(5'd12);
        check("R1 line 12 upper half", 32'(irr_o), 32'h1020);
        lower(5'd5);
        check("R4 lower line 5", 32'(irr_o), 32'h1000);
        lower(5'd12);
        check("R4 lower line 12", 32'(irr_o), 32'h0000);
    endtask

    task automatic t_cascade();
        raise(5'd2);
        check("R2 line 2 sets bits 2 and 9", 32'(irr_o), 32'h0204);
        check("R5 vector of line 2", 32'(vec), 32'h22);
        lower(5'd2);
        check("R2 lower line 2 keeps bit 9", 32'(irr_o), 32'h0200);
        check("R5 vector of line 9", 32'(vec), 32'h71);
        lower(5'd9);
        check("R4 lower line 9", 32'(irr_o), 32'h0);
    endtask

    task automatic t_bad_line();
        raise(5'd17);
        check("R3 bad raise leaves irr", 32'(irr_o), 32'h0);
        check("R3 raise_err set", {31'b0, raise_err}, 32'h1);
        @(negedge clk);
        check("R3 raise_err one cycle", {31'b0, raise_err}, 32'h0);
    endtask

    task automatic t_priority();
        raise(5'd7); raise(5'd10); raise(5'd4);
        check("R5 lowest line 4 wins", 32'(vec), 32'h24);
        mask_lo = 8'h10; #1;
        check("R5 masked line 4 skipped", 32'(vec), 32'h27);
        mask_lo = 8'hFF; #1;
        check("R5 upper half via base_hi", 32'(vec), 32'h72);
        mask_hi = 8'hFF; #1;
        check("R5 all masked no irq", {30'b0, irq_out, vec_valid}, 32'h0);
        check("R5 all masked vec zero", 32'(vec), 32'h0);
        mask_lo = 8'h00; mask_hi = 8'h00;
        lower(5'd7); lower(5'd10); lower(5'd4);
    endtask

    task automatic t_acknowledge();
        raise(5'd3); raise(5'd10);
        ack(8'h23);
        check("R6 ack lower irr", 32'(irr_o), 32'h0400);
        check("R6 ack lower isr", 32'(isr_o), 32'h0008);
        ack(8'h50);
        check("R6 ack outside windows irr", 32'(irr_o), 32'h0400);
        check("R6 ack outside windows isr", 32'(isr_o), 32'h0008);
        ack(8'h72);
        check("R6 ack upper irr", 32'(irr_o), 32'h0000);
        check("R6 ack upper isr", 32'(isr_o), 32'h0408);
    endtask

    task automatic t_end_of_interrupt();
        raise(5'd1); ack(8'h21);
        raise(5'd6); ack(8'h26);
        check("R6 isr before eoi", 32'(isr_o), 32'h044A);
        eoi(1'b0, 1'b0, 3'd0);
        check("R8 lowest bit retired", 32'(isr_o), 32'h0448);
        check("R9 no pending no eoi_err", {31'b0, eoi_err}, 32'h0);
        eoi(1'b0, 1'b1, 3'd6);
        check("R7 level 6 retired", 32'(isr_o), 32'h0408);
        raise(5'd5);
        eoi(1'b1, 1'b1, 3'd2);
        check("R7 upper level 2 retired", 32'(isr_o), 32'h0008);
        check("R9 pending after eoi", {31'b0, eoi_err}, 32'h1);
        @(negedge clk);
        check("R9 eoi_err one cycle", {31'b0, eoi_err}, 32'h0);
    endtask

    task automatic t_reset_mid();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R10 irr cleared mid-run", 32'(irr_o), 32'h0);
        check("R10 isr cleared mid-run", 32'(isr_o), 32'h0);
        check("R10 irq cleared mid-run", {31'b0, irq_out}, 32'h0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_line_map();
        t_cascade();
        t_bad_line();
        t_priority();
        t_acknowledge();
        t_end_of_interrupt();
        t_reset_mid();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule